// File: doc/BRIEF.md
# Column Power-Pulsing Sequencer

This block sits in the periphery of a pixel matrix with many columns. It moves the analog front end of the matrix between an active bias and a low-power sleep bias. One external pulse input selects the wanted state for the whole matrix: high asks for sleep and low asks for wake. When that input changes, the block steps through the columns in contiguous groups. Group 0 holds the lowest column indices. The group size is a power of two, chosen by a 3-bit field. Each column has its own sleep line. Sleeping is fast, so every group is put to sleep on back-to-back cycles. Waking is slow, so a programmable number of idle cycles separates successive groups.

Each bias DAC can be enrolled in pulsing on its own, and each enrolled DAC uses one of two methods. In code-swap mode the DAC output code changes from its stored active code to its stored sleep code. In select mode the code stays at the active value and a select line picks an alternate DAC output. A DAC that is not enrolled always shows its active code, and its select line stays low. A ready flag reports that the whole matrix is awake and that the last wake interval has run out.

The FSM has five states. AWAKE is the reset state. SLEEP_WALK sets one group per cycle. ASLEEP is entered after the last group has been set. WAKE_APPLY clears one group and loads the interval timer. WAKE_WAIT counts the interval down. The transitions are:
- AWAKE→SLEEP_WALK when the pin is high.
- SLEEP_WALK→ASLEEP after the last group has been set.
- SLEEP_WALK→WAKE_APPLY and ASLEEP→WAKE_APPLY when the pin is low.
- WAKE_APPLY→WAKE_WAIT.
- WAKE_WAIT→WAKE_APPLY when the timer has run out and more groups remain.
- WAKE_WAIT→AWAKE when the timer has run out after the last group.
- WAKE_APPLY→SLEEP_WALK and WAKE_WAIT→SLEEP_WALK when the pin is high.

Top module: `col_pulse_seq`

## Requirements
- R1: After reset, `col_sleep` is all zero and `ready` is 1. Every DAC code equals its active code and every `dac_sel` bit is 0.
- R2: The group size is 2^(`cfg_grp_sel`+1) columns, so 0 gives 2 columns and 7 gives 256. Group k holds columns k·size up to (k+1)·size−1.
- R3: Say the pin is first sampled high at edge e0. Group k is then set at edge e0+1+k. While the pin stays high, no sleep bit ever falls.
- R4: Say the pin is sampled low at edge e0 to start a wake, and S is `cfg_wake_step`. Group k is then cleared at edge e0+1+k·(S+2), and `ready` rises at edge e0+G·(S+2), where G is the number of groups. While the pin stays low, no sleep bit ever rises.
- R5: `ready` falls at the edge that samples the pin high. `ready` is never 1 while any sleep bit is set.
- R6: An enrolled DAC in code-swap mode (`cfg_dac_mux` bit 0) shows its sleep code from the edge that starts a sleep sequence. It shows its active code again from the edge that starts a wake sequence. Its select bit stays 0.
- R7: An enrolled DAC in select mode (`cfg_dac_mux` bit 1) keeps its active code. Its `dac_sel` bit is 1 over the same window as in R6.
- R8: A DAC whose `cfg_dac_en` bit is 0 always shows its active code, and its `dac_sel` bit is 0, whatever its mode bit is.
- R9: If the pin reverses during a sequence, the opposite sequence starts again from group 0 at the edge that samples the reversal. Columns that are already in the target state do not change.
- R10: The group size and the wake interval are captured when a sequence starts. Changing them during the sequence does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_pin | input | 1 | Synchronous matrix sleep request: 1 means sleep, 0 means wake |
| cfg_grp_sel | input | 3 | Group size select: the size is 2^(n+1) columns |
| cfg_wake_step | input | STEP_W | Idle cycles between wake groups |
| cfg_dac_en | input | NDAC | Enrols each DAC in pulsing |
| cfg_dac_mux | input | NDAC | Per-DAC method: 0 is code swap, 1 is output select |
| cfg_on_codes | input | NDAC·CODE_W | Active codes, DAC i in bits [i·CODE_W +: CODE_W] |
| cfg_off_codes | input | NDAC·CODE_W | Sleep codes, packed the same way |
| col_sleep | output | NCOL | Per-column sleep lines, 1 means asleep |
| dac_code | output | NDAC·CODE_W | Code driven to each DAC |
| dac_sel | output | NDAC | Alternate-output select for each DAC |
| ready | output | 1 | Matrix is fully awake and has settled |

## Verification
The hardest case to reach is a reversal that lands part-way through a sequence, because the untouched half of the matrix must keep its old state. The stimulus uses two groups. It drops the pin one cycle after a sleep starts, so only group 0 is asleep, and it raises the pin again inside the first wake interval of a full wake, so the upper half is still asleep. It then checks the sleep lines cycle by cycle. A second stimulus changes the group size and the interval in the middle of a wake, to show that the captured values govern the timing.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE      = 3'd0,
        ST_SLEEP_WALK = 3'd1,
        ST_ASLEEP     = 3'd2,
        ST_WAKE_APPLY = 3'd3,
        ST_WAKE_WAIT  = 3'd4
    } seq_state_e;

    // Shift amount that turns a column index into its group index.
    function automatic logic [3:0] grp_shift(input logic [2:0] sel);
        return {1'b0, sel} + 4'd1;
    endfunction

endpackage

// File: rtl/pp_grp_decode.sv
module pp_grp_decode #(
    parameter int NCOL   = 256,
    parameter int GIDX_W = $clog2(NCOL)
) (
    input  logic [GIDX_W-1:0] grp,
    input  logic [2:0]        sel,
    output logic [NCOL-1:0]   mask
);
    import pp_pkg::*;

    logic [3:0] shamt;
    assign shamt = grp_shift(sel);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [GIDX_W-1:0] cidx;
        assign cidx    = GIDX_W'(c);
        assign mask[c] = ((cidx >> shamt) == grp);
    end
endmodule

// File: rtl/pp_step_timer.sv
module pp_step_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pp_dac_drive.sv
module pp_dac_drive #(
    parameter int NDAC   = 4,
    parameter int CODE_W = 8
) (
    input  logic                   dac_off,
    input  logic [NDAC-1:0]        en,
    input  logic [NDAC-1:0]        mux,
    input  logic [NDAC*CODE_W-1:0] on_codes,
    input  logic [NDAC*CODE_W-1:0] off_codes,
    output logic [NDAC*CODE_W-1:0] code,
    output logic [NDAC-1:0]        sel
);
    for (genvar i = 0; i < NDAC; i++) begin : g_dac
        logic pulsed;
        assign pulsed = dac_off && en[i];
        assign code[i*CODE_W +: CODE_W] = (pulsed && !mux[i]) ?
                                          off_codes[i*CODE_W +: CODE_W] :
                                          on_codes[i*CODE_W +: CODE_W];
        assign sel[i] = pulsed && mux[i];
    end
endmodule

// File: rtl/col_pulse_seq.sv
module col_pulse_seq #(
    parameter int NCOL   = 256,
    parameter int NDAC   = 4,
    parameter int CODE_W = 8,
    parameter int STEP_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pulse_pin,
    input  logic [2:0]             cfg_grp_sel,
    input  logic [STEP_W-1:0]      cfg_wake_step,
    input  logic [NDAC-1:0]        cfg_dac_en,
    input  logic [NDAC-1:0]        cfg_dac_mux,
    input  logic [NDAC*CODE_W-1:0] cfg_on_codes,
    input  logic [NDAC*CODE_W-1:0] cfg_off_codes,
    output logic [NCOL-1:0]        col_sleep,
    output logic [NDAC*CODE_W-1:0] dac_code,
    output logic [NDAC-1:0]        dac_sel,
    output logic                   ready
);
    import pp_pkg::*;

    localparam int GIDX_W = $clog2(NCOL);
    localparam int NCNT_W = GIDX_W + 1;

    seq_state_e          state_q, state_d;
    logic [NCOL-1:0]     col_sleep_q;
    logic [GIDX_W-1:0]   grp_q;
    logic [2:0]          sel_q;
    logic [STEP_W-1:0]   step_q;
    logic                dac_off_q;
    logic                ready_q;

    logic [NCOL-1:0]     grp_mask;
    logic [NCNT_W-1:0]   ngrp;
    logic [GIDX_W-1:0]   last_idx;
    logic                is_last;
    logic                tmr_zero;
    logic                seq_start;

    // Number of groups and the index of the last one, from the captured size.
    assign ngrp     = NCNT_W'(NCOL) >> grp_shift(sel_q);
    assign last_idx = GIDX_W'(ngrp - NCNT_W'(1));
    assign is_last  = (grp_q == last_idx);

    pp_grp_decode #(.NCOL(NCOL), .GIDX_W(GIDX_W)) u_dec (
        .grp  (grp_q),
        .sel  (sel_q),
        .mask (grp_mask)
    );

    pp_step_timer #(.W(STEP_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_WAKE_APPLY),
        .load_val (step_q),
        .zero     (tmr_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    // Next-state logic: the pin always takes priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:      if (pulse_pin) state_d = ST_SLEEP_WALK;
            ST_SLEEP_WALK: begin
                if (!pulse_pin)   state_d = ST_WAKE_APPLY;
                else if (is_last) state_d = ST_ASLEEP;
            end
            ST_ASLEEP:     if (!pulse_pin) state_d = ST_WAKE_APPLY;
            ST_WAKE_APPLY: state_d = pulse_pin ? ST_SLEEP_WALK : ST_WAKE_WAIT;
            ST_WAKE_WAIT: begin
                if (pulse_pin)     state_d = ST_SLEEP_WALK;
                else if (tmr_zero) state_d = is_last ? ST_AWAKE : ST_WAKE_APPLY;
            end
            default:       state_d = ST_AWAKE;
        endcase
    end

    assign seq_start = ((state_d == ST_SLEEP_WALK) && (state_q != ST_SLEEP_WALK)) ||
                       ((state_d == ST_WAKE_APPLY) &&
                        ((state_q == ST_SLEEP_WALK) || (state_q == ST_ASLEEP)));

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_sleep_q <= '0;
            grp_q       <= '0;
            sel_q       <= '0;
            step_q      <= '0;
            dac_off_q   <= 1'b0;
            ready_q     <= 1'b1;
        end else begin
            ready_q <= (state_d == ST_AWAKE);
            if (seq_start) begin
                grp_q     <= '0;
                sel_q     <= cfg_grp_sel;
                step_q    <= cfg_wake_step;
                dac_off_q <= (state_d == ST_SLEEP_WALK);
            end else begin
                unique case (state_q)
                    ST_SLEEP_WALK: begin
                        col_sleep_q <= col_sleep_q | grp_mask;
                        grp_q       <= grp_q + GIDX_W'(1);
                    end
                    ST_WAKE_APPLY: col_sleep_q <= col_sleep_q & ~grp_mask;
                    ST_WAKE_WAIT:  if (tmr_zero && !is_last) grp_q <= grp_q + GIDX_W'(1);
                    default: ;
                endcase
            end
        end
    end

    pp_dac_drive #(.NDAC(NDAC), .CODE_W(CODE_W)) u_dac (
        .dac_off   (dac_off_q),
        .en        (cfg_dac_en),
        .mux       (cfg_dac_mux),
        .on_codes  (cfg_on_codes),
        .off_codes (cfg_off_codes),
        .code      (dac_code),
        .sel       (dac_sel)
    );

    assign col_sleep = col_sleep_q;
    assign ready     = ready_q;
endmodule

// File: rtl/col_pulse_seq_chk.sv
module col_pulse_seq_chk #(
    parameter int NCOL   = 256,
    parameter int NDAC   = 4,
    parameter int CODE_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pulse_pin,
    input logic [NDAC-1:0]        cfg_dac_en,
    input logic [NDAC-1:0]        cfg_dac_mux,
    input logic [NDAC*CODE_W-1:0] cfg_on_codes,
    input logic [NCOL-1:0]        col_sleep,
    input logic [NDAC*CODE_W-1:0] dac_code,
    input logic [NDAC-1:0]        dac_sel,
    input logic                   ready
);
    // R5
    ready_all_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (col_sleep == '0));

    // R5
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_pin |=> !ready);

    // R3
    sleep_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pulse_pin) |-> (($past(col_sleep) & ~col_sleep) == '0));

    // R4
    wake_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pulse_pin) |-> ((~$past(col_sleep) & col_sleep) == '0));

    // R7
    sel_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sel & ~(cfg_dac_en & cfg_dac_mux)) == '0);

    for (genvar i = 0; i < NDAC; i++) begin : g_dis
        // R8
        idle_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_dac_en[i] |-> ((dac_code[i*CODE_W +: CODE_W] ==
                                 cfg_on_codes[i*CODE_W +: CODE_W]) && !dac_sel[i]));
    end
endmodule

bind col_pulse_seq col_pulse_seq_chk #(.NCOL(NCOL), .NDAC(NDAC), .CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pulse_pin    (pulse_pin),
    .cfg_dac_en   (cfg_dac_en),
    .cfg_dac_mux  (cfg_dac_mux),
    .cfg_on_codes (cfg_on_codes),
    .col_sleep    (col_sleep),
    .dac_code     (dac_code),
    .dac_sel      (dac_sel),
    .ready        (ready)
);

// File: tb/sim_col_pulse_seq.sv
module sim_col_pulse_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NCOL = 256, NDAC = 4, CODE_W = 8, STEP_W = 16;

    logic clk = 1'b0, rst_n = 1'b0, pulse_pin = 1'b0;
    logic [2:0]             cfg_grp_sel = 3'd5;
    logic [STEP_W-1:0]      cfg_wake_step = 16'd3;
    logic [NDAC-1:0]        cfg_dac_en  = 4'b1011;
    logic [NDAC-1:0]        cfg_dac_mux = 4'b0110;
    logic [NDAC*CODE_W-1:0] cfg_on_codes  = {8'h13, 8'h12, 8'h11, 8'h10};
    logic [NDAC*CODE_W-1:0] cfg_off_codes = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    logic [NCOL-1:0]        col_sleep;
    logic [NDAC*CODE_W-1:0] dac_code;
    logic [NDAC-1:0]        dac_sel;
    logic                   ready;

    col_pulse_seq #(.NCOL(NCOL), .NDAC(NDAC), .CODE_W(CODE_W), .STEP_W(STEP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pulse_pin(pulse_pin),
        .cfg_grp_sel(cfg_grp_sel), .cfg_wake_step(cfg_wake_step),
        .cfg_dac_en(cfg_dac_en), .cfg_dac_mux(cfg_dac_mux),
        .cfg_on_codes(cfg_on_codes), .cfg_off_codes(cfg_off_codes),
        .col_sleep(col_sleep), .dac_code(dac_code), .dac_sel(dac_sel), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int              at;
        logic [NCOL-1:0] sl;
        logic            rdy;
        logic            off;
        string           tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    // Low n columns set
    function automatic logic [NCOL-1:0] low_n(int n);
        logic [NCOL-1:0] m = '0;
        for (int c = 0; c < n; c++) m[c] = 1'b1;
        return m;
    endfunction

    // Expected DAC outputs from R6, R7, R8: DAC0 and DAC3 code swap, DAC1 select, DAC2 not enrolled
    function automatic logic [NDAC*CODE_W-1:0] exp_code(logic off);
        logic [NDAC*CODE_W-1:0] r;
        for (int i = 0; i < NDAC; i++)
            r[i*CODE_W +: CODE_W] = (off && cfg_dac_en[i] && !cfg_dac_mux[i]) ?
                cfg_off_codes[i*CODE_W +: CODE_W] : cfg_on_codes[i*CODE_W +: CODE_W];
        return r;
    endfunction

    task automatic push(int at, logic [NCOL-1:0] sl, logic rdy, logic off, string tag);
        exp_t e;
        e.at = at; e.sl = sl; e.rdy = rdy; e.off = off; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: pops and compares at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic [NDAC-1:0] esel;
            e = sb.pop_front();
            esel = e.off ? (cfg_dac_en & cfg_dac_mux) : '0;
            n_chk++;
            if (e.at != cyc || col_sleep !== e.sl || ready !== e.rdy ||
                dac_code !== exp_code(e.off) || dac_sel !== esel) begin
                n_fail++;
                $display("FAIL %s cyc=%0d(exp %0d) sleep=%h/%h ready=%b/%b code=%h/%h sel=%b/%b",
                         e.tag, cyc, e.at, col_sleep, e.sl, ready, e.rdy,
                         dac_code, exp_code(e.off), dac_sel, esel);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        int t0, t1, tw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R8: reset state
        push(cyc + 1, '0, 1'b1, 1'b0, "R1 reset");
        wait_to(cyc + 2);

        // R3 R5 R6 R7 R2: sleep with 64-column groups
        @(negedge clk); pulse_pin = 1'b1; t0 = cyc + 1;
        push(t0, '0, 1'b0, 1'b1, "R5 ready drop");
        for (int k = 0; k < 4; k++)
            push(t0 + k + 1, low_n((k + 1) * 64), 1'b0, 1'b1, "R3 sleep walk");
        wait_to(t0 + 6);

        // R4 R10: wake, interval 3, then change config mid-wake
        @(negedge clk); pulse_pin = 1'b0; t1 = cyc + 1;
        push(t1, '1, 1'b0, 1'b0, "R6 code restore");
        for (int k = 0; k < 4; k++) begin
            if (k > 0) push(t1 + k * 5, ~low_n(k * 64), 1'b0, 1'b0, "R4 wake spacing");
            push(t1 + k * 5 + 1, ~low_n((k + 1) * 64), 1'b0, 1'b0, "R4 wake group");
        end
        push(t1 + 19, '0, 1'b0, 1'b0, "R4 ready early");
        push(t1 + 20, '0, 1'b1, 1'b0, "R4 ready rise");
        wait_to(t1 + 2);
        cfg_wake_step = 16'd50; cfg_grp_sel = 3'd0;   // R10: must not alter this wake
        wait_to(t1 + 22);

        // R2: 2-column groups, then one 256-column group
        @(negedge clk); pulse_pin = 1'b1; t0 = cyc + 1;
        push(t0 + 1, low_n(2), 1'b0, 1'b1, "R2 size 2");
        push(t0 + 2, low_n(4), 1'b0, 1'b1, "R2 size 2 next");
        push(t0 + 127, low_n(254), 1'b0, 1'b1, "R2 before last");
        push(t0 + 128, '1, 1'b0, 1'b1, "R2 last group");
        wait_to(t0 + 130);
        cfg_grp_sel = 3'd7; cfg_wake_step = 16'd0;
        @(negedge clk); pulse_pin = 1'b0; t1 = cyc + 1;
        push(t1 + 1, '0, 1'b0, 1'b0, "R2 size 256");
        push(t1 + 2, '0, 1'b1, 1'b0, "R4 ready step0");
        wait_to(t1 + 4);

        // R9: reversal during sleep, 128-column groups, interval 10
        cfg_grp_sel = 3'd6; cfg_wake_step = 16'd10;
        @(negedge clk); pulse_pin = 1'b1; t0 = cyc + 1;
        tw = t0 + 2;
        push(t0 + 1, low_n(128), 1'b0, 1'b1, "R9 half asleep");
        push(tw, low_n(128), 1'b0, 1'b0, "R9 upper untouched");
        push(tw + 1, '0, 1'b0, 1'b0, "R9 restart group0");
        push(tw + 23, '0, 1'b0, 1'b0, "R9 ready early");
        push(tw + 24, '0, 1'b1, 1'b0, "R9 ready rise");
        wait_to(t0 + 1);
        pulse_pin = 1'b0;
        wait_to(tw + 26);

        // R9: reversal during wake
        @(negedge clk); pulse_pin = 1'b1; t0 = cyc + 1;
        push(t0 + 2, '1, 1'b0, 1'b1, "R3 all asleep");
        wait_to(t0 + 3);
        @(negedge clk); pulse_pin = 1'b0; t1 = cyc + 1;
        push(t1 + 1, ~low_n(128), 1'b0, 1'b0, "R9 low half awake");
        push(t1 + 5, ~low_n(128), 1'b0, 1'b1, "R9 sleep restart");
        push(t1 + 6, '1, 1'b0, 1'b1, "R9 group0 resleep");
        push(t1 + 7, '1, 1'b0, 1'b1, "R9 stays asleep");
        wait_to(t1 + 4);
        pulse_pin = 1'b1;
        wait_to(t1 + 9);

        // R8: disabled DAC unaffected after unenrolling DAC3 while asleep
        cfg_dac_en = 4'b0011;
        push(cyc + 1, '1, 1'b0, 1'b1, "R8 unenrolled");
        wait_to(cyc + 3);

        if (sb.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule